// File: doc/BRIEF.md
# Trap Vector and Return Unit

This unit decides where instruction fetch goes when an exception event is taken, and where it goes back to when the privileged return instruction runs. A fault, trap or interrupt arrives as a 4-bit event code together with the PC of the affected instruction and the core's privileged-mode flag. The unit adds a per-event offset to a programmable vector base and emits the redirect target and the following fetch address. It also records the restart address that the handler later returns to.

The unit also owns the shadow-bank state for the small set of integer registers that have privileged copies. It tells the register file when to exchange the bank and which register indices are currently served from the shadow copy. It flags any request to enter a bank state that is already active; such a request does not exchange anything.

An interrupt-check enable output goes low when any event is taken and goes high again after a legal return.

Top module: `trap_vector_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs are: `redir_pc` = `RESET_BASE`+0x1, `redir_npc` = `RESET_BASE`+0x5, `redir_valid` 0, `exc_addr` 0, `shadow_active` 1, `intr_chk_en` 0, and `swap_go` and `swap_err` both 0.
- R2: The event codes and their vector offsets are:
    - 0 machine check 0x401
    - 1 arithmetic 0x501
    - 2 interrupt 0x101
    - 3 data-translation miss, native 0x201
    - 4 data-translation miss, privileged 0x281
    - 5 alignment 0x301
    - 6 data fault 0x381
    - 7 data access violation 0x381
    - 8 instruction-translation miss 0x181
    - 9 instruction fault 0x181
    - 10 instruction access violation 0x081
    - 11 unimplemented opcode 0x481
    - 12 FP disabled 0x581
    - 13 privileged call 0x2001
    - 14 integer overflow 0x501
    - 15 reserved, treated as 0x481
- R3: One cycle after `ev_valid` is sampled, `redir_valid` is 1, `redir_pc` equals the vector base plus the event's offset, and `redir_npc` equals `redir_pc`+4. `redir_valid` is 0 in cycles without a redirect, and `redir_pc`/`redir_npc` then hold their values.
- R4: A taken event loads `exc_addr` with `cur_pc`. The exception is an interrupt (code 2) taken while `in_priv` is 1, which leaves `exc_addr` unchanged.
- R5: For codes 1, 13 and 14, the saved restart address is `cur_pc`+4.
- R6: An event taken with `in_priv` 0 requests a swap-in. If the shadow bank is inactive, `swap_go` pulses with `swap_dir` 1 and `shadow_active` becomes 1.
- R7: `rf_shadow` is 1 exactly when `shadow_active` is 1 and `rf_idx` is one of 8 to 14 or 25.
- R8: A return (`ret_valid` with `in_priv` 1 and no event) redirects to `exc_addr`, with `redir_npc` = `exc_addr`+4. It sets `intr_chk_en` to 1 and leaves `exc_addr` unchanged.
- R9: A return swaps the bank out (`swap_go` with `swap_dir` 0, `shadow_active` becoming 0) only when bit 0 of `exc_addr` is 0. When that bit is 1, no swap happens.
- R10: A return with `in_priv` 0 is taken as event code 11. It redirects to base+0x481 and saves `cur_pc`, following the rules of R4 and R6.
- R11: A swap request into the state that is already active pulses `swap_err` for one cycle, with `swap_go` 0 and `shadow_active` unchanged.
- R12: `base_we` loads the vector base from `base_wdata`. An event in the same cycle still uses the old base, and later events use the new one.
- R13: When `ev_valid` and `ret_valid` are both high, the event wins and the return has no effect. Every taken event clears `intr_chk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Take an exception event this cycle |
| ev_code | input | 4 | Event code (R2) |
| cur_pc | input | AW | PC of the affected instruction |
| in_priv | input | 1 | Core is currently in privileged mode |
| ret_valid | input | 1 | Privileged return instruction executes |
| base_we | input | 1 | Load the vector base register |
| base_wdata | input | AW | New vector base value |
| rf_idx | input | IW | Integer register index to classify |
| redir_valid | output | 1 | Fetch redirect this cycle |
| redir_pc | output | AW | Redirect target |
| redir_npc | output | AW | Fetch address after the target |
| exc_addr | output | AW | Saved restart address |
| shadow_active | output | 1 | Shadow bank currently swapped in |
| swap_go | output | 1 | Exchange the shadow bank now |
| swap_dir | output | 1 | 1 swap in, 0 swap out |
| swap_err | output | 1 | Swap request into the already active state |
| rf_shadow | output | 1 | `rf_idx` is served from the shadow copy |
| intr_chk_en | output | 1 | Interrupt checking enabled |

## Verification
All sixteen event codes are taken both from privileged mode and from normal mode. This separates the offset lookup from the restart rule, and the interrupt-in-privileged case from every other event. Between these events, returns through even and odd restart addresses distinguish the swap-out case from the stay-privileged case. Repeated entries from normal mode with the bank already in show the error path. A base write issued alongside an event, an event paired with a return, and an illegal return each isolate one ordering rule. The register-index sweep with the bank both in and out tells the shadowed subset apart from the others.

// File: rtl/tvu_pkg.sv
package tvu_pkg;

    typedef enum logic [3:0] {
        EV_MCHK     = 4'd0,
        EV_ARITH    = 4'd1,
        EV_INTR     = 4'd2,
        EV_DMISS_N  = 4'd3,
        EV_DMISS_P  = 4'd4,
        EV_ALIGN    = 4'd5,
        EV_DFAULT   = 4'd6,
        EV_DACV     = 4'd7,
        EV_IMISS    = 4'd8,
        EV_IFAULT   = 4'd9,
        EV_IACV     = 4'd10,
        EV_OPC      = 4'd11,
        EV_FPOFF    = 4'd12,
        EV_PCALL    = 4'd13,
        EV_IOVF     = 4'd14,
        EV_RSVD     = 4'd15
    } ev_code_e;

    localparam int OFS_W = 14;

    typedef struct packed {
        logic go;
        logic dir;
        logic err;
    } swap_evt_t;

    // Offset from vector base; bit 0 marks privileged fetch.
    function automatic logic [OFS_W-1:0] vec_offset(ev_code_e c);
        case (c)
            EV_MCHK:               return 14'h0401;
            EV_ARITH, EV_IOVF:     return 14'h0501;
            EV_INTR:               return 14'h0101;
            EV_DMISS_N:            return 14'h0201;
            EV_DMISS_P:            return 14'h0281;
            EV_ALIGN:              return 14'h0301;
            EV_DFAULT, EV_DACV:    return 14'h0381;
            EV_IMISS, EV_IFAULT:   return 14'h0181;
            EV_IACV:               return 14'h0081;
            EV_FPOFF:              return 14'h0581;
            EV_PCALL:              return 14'h2001;
            default:               return 14'h0481;
        endcase
    endfunction

    localparam logic [OFS_W-1:0] RESET_OFS = 14'h0001;

    // Trap-type events resume after the trapping instruction.
    function automatic logic skips_insn(ev_code_e c);
        return (c == EV_PCALL) || (c == EV_ARITH) || (c == EV_IOVF);
    endfunction

    function automatic logic is_shadowed(int unsigned idx);
        return ((idx >= 8) && (idx <= 14)) || (idx == 25);
    endfunction

endpackage

// File: rtl/tvu_vector.sv
module tvu_vector
    import tvu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  ev_code_e      code,
    output logic [AW-1:0] tgt_pc,
    output logic [AW-1:0] tgt_npc
);
    localparam logic [AW-1:0] INSN_BYTES = AW'(4);

    always_comb begin
        tgt_pc  = base + AW'(vec_offset(code));
        tgt_npc = tgt_pc + INSN_BYTES;
    end
endmodule

// File: rtl/tvu_restart.sv
module tvu_restart
    import tvu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          take,
    input  ev_code_e      code,
    input  logic [AW-1:0] cur_pc,
    input  logic          in_priv,
    input  logic [AW-1:0] exc_q,
    output logic [AW-1:0] exc_d
);
    localparam logic [AW-1:0] INSN_BYTES = AW'(4);

    logic keep_old;

    always_comb begin
        keep_old = !take || ((code == EV_INTR) && in_priv);
        if (keep_old)
            exc_d = exc_q;
        else if (skips_insn(code))
            exc_d = cur_pc + INSN_BYTES;
        else
            exc_d = cur_pc;
    end
endmodule

// File: rtl/tvu_shadow.sv
module tvu_shadow
    import tvu_pkg::*;
#(
    parameter int NREG = 32,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_in,
    input  logic          req_out,
    input  logic [IW-1:0] rf_idx,
    output logic          active,
    output swap_evt_t     evt,
    output logic          rf_shadow
);
    swap_evt_t evt_d;
    logic      active_d;

    always_comb begin
        evt_d    = '0;
        active_d = active;
        if (req_in) begin
            evt_d.dir = 1'b1;
            if (active) evt_d.err = 1'b1;
            else begin
                evt_d.go = 1'b1;
                active_d = 1'b1;
            end
        end else if (req_out) begin
            if (!active) evt_d.err = 1'b1;
            else begin
                evt_d.go = 1'b1;
                active_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            evt    <= '0;
        end else begin
            active <= active_d;
            evt    <= evt_d;
        end
    end

    logic [NREG-1:0] shadow_map;
    for (genvar g = 0; g < NREG; g++) begin : g_map
        assign shadow_map[g] = is_shadowed(g);
    end

    assign rf_shadow = active && shadow_map[rf_idx];
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
    import tvu_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          NREG       = 32,
    parameter logic [AW-1:0] RESET_BASE = 32'h0000_8000,
    localparam int         IW         = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_valid,
    input  logic [3:0]    ev_code,
    input  logic [AW-1:0] cur_pc,
    input  logic          in_priv,
    input  logic          ret_valid,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic [IW-1:0] rf_idx,
    output logic          redir_valid,
    output logic [AW-1:0] redir_pc,
    output logic [AW-1:0] redir_npc,
    output logic [AW-1:0] exc_addr,
    output logic          shadow_active,
    output logic          swap_go,
    output logic          swap_dir,
    output logic          swap_err,
    output logic          rf_shadow,
    output logic          intr_chk_en
);
    localparam logic [AW-1:0] INSN_BYTES = AW'(4);
    localparam logic [AW-1:0] RESET_PC   = RESET_BASE + AW'(RESET_OFS);

    logic [AW-1:0] base_q;
    logic          take, ill_ret, legal_ret;
    ev_code_e      eff_code;
    logic [AW-1:0] vec_pc, vec_npc, exc_d;
    swap_evt_t     sw_evt;

    always_comb begin
        ill_ret   = ret_valid && !ev_valid && !in_priv;
        legal_ret = ret_valid && !ev_valid && in_priv;
        take      = ev_valid || ill_ret;
        eff_code  = ev_valid ? ev_code_e'(ev_code) : EV_OPC;
    end

    tvu_vector #(.AW(AW)) u_vec (
        .base    (base_q),
        .code    (eff_code),
        .tgt_pc  (vec_pc),
        .tgt_npc (vec_npc)
    );

    tvu_restart #(.AW(AW)) u_rst (
        .take    (take),
        .code    (eff_code),
        .cur_pc  (cur_pc),
        .in_priv (in_priv),
        .exc_q   (exc_addr),
        .exc_d   (exc_d)
    );

    tvu_shadow #(.NREG(NREG)) u_shd (
        .clk       (clk),
        .rst       (rst),
        .req_in    (take && !in_priv),
        .req_out   (legal_ret && !exc_addr[0]),
        .rf_idx    (rf_idx),
        .active    (shadow_active),
        .evt       (sw_evt),
        .rf_shadow (rf_shadow)
    );

    assign swap_go  = sw_evt.go;
    assign swap_dir = sw_evt.dir;
    assign swap_err = sw_evt.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q      <= RESET_BASE;
            redir_valid <= 1'b0;
            redir_pc    <= RESET_PC;
            redir_npc   <= RESET_PC + INSN_BYTES;
            exc_addr    <= '0;
            intr_chk_en <= 1'b0;
        end else begin
            if (base_we) base_q <= base_wdata;
            exc_addr    <= exc_d;
            redir_valid <= take || legal_ret;
            if (take) begin
                redir_pc    <= vec_pc;
                redir_npc   <= vec_npc;
                intr_chk_en <= 1'b0;
            end else if (legal_ret) begin
                redir_pc    <= exc_addr;
                redir_npc   <= exc_addr + INSN_BYTES;
                intr_chk_en <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/trap_vector_unit_chk.sv
module trap_vector_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          ev_valid,
    input logic [3:0]    ev_code,
    input logic          in_priv,
    input logic          ret_valid,
    input logic          redir_valid,
    input logic [AW-1:0] redir_pc,
    input logic [AW-1:0] redir_npc,
    input logic [AW-1:0] exc_addr,
    input logic          shadow_active,
    input logic          swap_go,
    input logic          swap_err,
    input logic          intr_chk_en
);
    assert_npc_follows_R3: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (redir_npc == redir_pc + AW'(4)));

    assert_intr_priv_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_code == 4'd2 && in_priv) |=> $stable(exc_addr));

    assert_ret_target_R8: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !ev_valid && in_priv) |=> (redir_pc == $past(exc_addr) && intr_chk_en));

    assert_bank_moves_only_on_go_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(shadow_active) |-> swap_go);

    assert_err_excl_R11: assert property (@(posedge clk) disable iff (rst)
        swap_err |-> !swap_go);

    assert_event_clears_chk_R13: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> (!intr_chk_en && redir_valid));
endmodule

bind trap_vector_unit trap_vector_unit_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ev_valid      (ev_valid),
    .ev_code       (ev_code),
    .in_priv       (in_priv),
    .ret_valid     (ret_valid),
    .redir_valid   (redir_valid),
    .redir_pc      (redir_pc),
    .redir_npc     (redir_npc),
    .exc_addr      (exc_addr),
    .shadow_active (shadow_active),
    .swap_go       (swap_go),
    .swap_err      (swap_err),
    .intr_chk_en   (intr_chk_en)
);

// File: tb/sim_trap_vector_unit.sv
`timescale 1ns/1ps
module sim_trap_vector_unit;
    localparam int AW = 32;
    localparam int NREG = 32;
    localparam int IW = 5;
    localparam logic [31:0] RB = 32'h0000_8000;

    logic clk = 1'b0, rst = 1'b1;
    logic ev_valid = 0, in_priv = 0, ret_valid = 0, base_we = 0;
    logic [3:0] ev_code = 0;
    logic [31:0] cur_pc = 0, base_wdata = 0;
    logic [IW-1:0] rf_idx = 0;
    logic redir_valid, shadow_active, swap_go, swap_dir, swap_err, rf_shadow, intr_chk_en;
    logic [31:0] redir_pc, redir_npc, exc_addr;

    int n_tests = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    trap_vector_unit #(.AW(AW), .NREG(NREG), .RESET_BASE(RB)) u0 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code), .cur_pc(cur_pc),
        .in_priv(in_priv), .ret_valid(ret_valid), .base_we(base_we), .base_wdata(base_wdata),
        .rf_idx(rf_idx), .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_npc(redir_npc),
        .exc_addr(exc_addr), .shadow_active(shadow_active), .swap_go(swap_go),
        .swap_dir(swap_dir), .swap_err(swap_err), .rf_shadow(rf_shadow), .intr_chk_en(intr_chk_en));

    // bench model state
    logic [31:0] m_base = RB, m_exc = 0, m_pc = RB + 1;
    logic m_act = 1'b1, m_chk = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] exp_off(int c);
        case (c)
            0: return 32'h401;   1: return 32'h501;   2: return 32'h101;
            3: return 32'h201;   4: return 32'h281;   5: return 32'h301;
            6: return 32'h381;   7: return 32'h381;   8: return 32'h181;
            9: return 32'h181;  10: return 32'h081;  11: return 32'h481;
           12: return 32'h581;  13: return 32'h2001; 14: return 32'h501;
           default: return 32'h481;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One stimulus cycle with model update and full output comparison.
    task automatic step(string tag, logic ev, int code, logic [31:0] pc, logic priv,
                        logic ret, logic bwe, logic [31:0] bdata);
        logic take, legal, rin, rout, e_go, e_err, e_dir, e_valid;
        int ec;
        @(negedge clk);
        ev_valid = ev; ev_code = 4'(code); cur_pc = pc; in_priv = priv;
        ret_valid = ret; base_we = bwe; base_wdata = bdata;
        take = ev || (ret && !priv);
        legal = ret && !ev && priv;
        ec = ev ? code : 11;
        rin = 0; rout = 0; e_valid = take || legal;
        if (take) begin
            m_pc = m_base + exp_off(ec);
            m_chk = 0;
            rin = !priv;
        end else if (legal) begin
            m_pc = m_exc;
            m_chk = 1;
            rout = !m_exc[0];
        end
        if (take && !(ec == 2 && priv))
            m_exc = pc + ((ec == 1 || ec == 13 || ec == 14) ? 32'd4 : 32'd0);
        e_go = 0; e_err = 0; e_dir = rin;
        if (rin) begin if (m_act) e_err = 1; else begin e_go = 1; m_act = 1; end end
        else if (rout) begin if (!m_act) e_err = 1; else begin e_go = 1; m_act = 0; end end
        if (bwe) m_base = bdata;
        @(posedge clk); #1;
        chk({tag, " R3 valid"}, {31'd0, redir_valid}, {31'd0, e_valid});
        chk({tag, " R3 pc"}, redir_pc, m_pc);
        chk({tag, " R3 npc"}, redir_npc, m_pc + 4);
        chk({tag, " R4 exc"}, exc_addr, m_exc);
        chk({tag, " R6 active"}, {31'd0, shadow_active}, {31'd0, m_act});
        chk({tag, " R6 go"}, {31'd0, swap_go}, {31'd0, e_go});
        if (e_go) chk({tag, " R9 dir"}, {31'd0, swap_dir}, {31'd0, e_dir});
        chk({tag, " R11 err"}, {31'd0, swap_err}, {31'd0, e_err});
        chk({tag, " R13 chk"}, {31'd0, intr_chk_en}, {31'd0, m_chk});
        @(negedge clk);
        ev_valid = 0; ret_valid = 0; base_we = 0;
    endtask

    task automatic rf_sweep(string tag);
        for (int i = 0; i < NREG; i++) begin
            rf_idx = 5'(i);
            #1;
            chk({tag, " R7 rf_shadow"}, {31'd0, rf_shadow},
                {31'd0, m_act && ((i >= 8 && i <= 14) || i == 25)});
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pc in reset", redir_pc, RB + 1);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        chk("R1 pc", redir_pc, RB + 1);
        chk("R1 npc", redir_npc, RB + 5);
        chk("R1 valid", {31'd0, redir_valid}, 0);
        chk("R1 exc", exc_addr, 0);
        chk("R1 active", {31'd0, shadow_active}, 1);
        chk("R1 chk", {31'd0, intr_chk_en}, 0);
        chk("R1 go/err", {30'd0, swap_go, swap_err}, 0);
        rf_sweep("R1/R7 bank in");

        // R2 R4 R5 R6 R9 R11: every code from both modes
        for (int c = 0; c < 16; c++) begin
            step("R2 priv entry", 1, c, 32'h1000 + 32'(c) * 16, 1, 0, 0, 0);
            step("R9 ret even", 0, 0, 32'h0, 1, 1, 0, 0);
            step("R6 user entry", 1, c, 32'h2000 + 32'(c) * 16, 0, 0, 0, 0);
            step("R11 user entry bank in", 1, c, 32'h3000 + 32'(c) * 16, 0, 0, 0, 0);
        end
        rf_sweep("R7 bank in");

        // R9: odd restart keeps privileged mode
        step("R9 set odd", 1, 0, 32'h4001, 1, 0, 0, 0);
        step("R9 ret odd", 0, 0, 32'h0, 1, 1, 0, 0);
        step("R9 ret odd again", 0, 0, 32'h0, 1, 1, 0, 0);
        // R4: interrupt in privileged mode keeps restart
        step("R4 intr priv", 1, 2, 32'h5550, 1, 0, 0, 0);
        step("R5 pcall priv", 1, 13, 32'h6000, 1, 0, 0, 0);
        step("R8 ret", 0, 0, 32'h0, 1, 1, 0, 0);
        rf_sweep("R7 bank out");
        step("R11 ret bank out", 0, 0, 32'h0, 1, 1, 0, 0);
        // R10: illegal return from normal mode
        step("R10 illegal ret", 0, 0, 32'h7770, 0, 1, 0, 0);
        // R12: base write with same-cycle event
        step("R12 same cycle", 1, 5, 32'h8880, 1, 0, 1, 32'h0010_0000);
        step("R12 new base", 1, 12, 32'h8890, 1, 0, 0, 0);
        // R13: event beats return
        step("R13 ev+ret", 1, 8, 32'h9990, 1, 1, 0, 0);
        step("R13 ret after", 0, 0, 32'h0, 1, 1, 0, 0);
        step("R13 idle", 0, 0, 32'h0, 1, 0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule